// File: doc/BRIEF.md
# Loop-Filter Up/Down Counter With Wrap Pulses

This block is the loop filter of an all-digital phase-locked loop. It runs on the fast clock, which is M times the loop centre frequency. On every enabled clock it steps a count up or down. The phase detector drives the direction input. The count lives in the range 0 to K-1. When it wraps past the top it raises a one-clock carry pulse, and when it wraps past the bottom it raises a one-clock borrow pulse. A downstream pulse add/delete stage turns those pulses into phase corrections. The modulus K sets the loop gain (fc/K): a larger K gives a slower and smoother loop.

K is a power of two. A 4-bit code selects it, and the code is captured only while the synchronous reset is asserted. Reset also starts the count at mid-range, K/2, so that the first carry and the first borrow are equally far away.

Top module: `pll_kcounter`

## Requirements
- R1: While rst is high at a clock edge, the modulus is loaded as K = 2^(3+kCode) for kCode 0..14 (K = 8 .. 131072). Any kCode above 14 gives K = 131072. After that edge count equals K/2 and carry and borrow are low.
- R2: With rst low, en high and up high, a count below K-1 rises by exactly one at each clock.
- R3: With rst low, en high and up high, a count of K-1 goes to 0 at the clock edge. carry is high for the single cycle that follows that edge.
- R4: With rst low, en high and up low, a count above 0 falls by exactly one at each clock.
- R5: With rst low, en high and up low, a count of 0 goes to K-1 at the clock edge. borrow is high for the single cycle that follows that edge.
- R6: With rst low and en low, count holds its value and neither carry nor borrow is raised.
- R7: carry and borrow are never high together, and neither is high for two cycles in a row.
- R8: A change of kCode while rst is low has no effect on the modulus. The wrap point stays at the K loaded by the last reset.
- R9: count is always below the loaded K.
- R10: rst takes priority over en and up in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, M times the loop centre frequency |
| rst | input | 1 | Synchronous reset; loads the modulus and centres the count |
| en | input | 1 | Count enable |
| up | input | 1 | Direction from the phase detector: 1 counts up, 0 counts down |
| kCode | input | 4 | Modulus select, captured only during reset |
| count | output | 17 | Present count, 0 to K-1 |
| carry | output | 1 | One-clock pulse after an upward wrap |
| borrow | output | 1 | One-clock pulse after a downward wrap |

## Verification
A corrupted count or modulus shows up directly on the count port in the next cycle. It also moves the cycle in which carry or borrow appears, so a full sweep through the wrap points exposes it within one modulus period. A stale modulus, loaded outside reset, places the wrap at the wrong count, and a step sequence longer than the smaller K catches it. Pulse faults are caught in the first cycle after a wrap: a stretched pulse, a pulse in both directions, or a pulse while disabled.

// File: rtl/pll_kcounter_pkg.sv
package pll_kcounter_pkg;
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
    logic wrapUp;
    logic wrapDn;
  } kcntStrobe_t;
endpackage

// File: rtl/pll_kcounter_dp.sv
module pll_kcounter_dp
  import pll_kcounter_pkg::*;
#(
  parameter int CNT_W   = 17,
  parameter int CODE_W  = 4,
  parameter int MIN_LOG = 3,
  parameter int MAX_LOG = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  kcntStrobe_t       strobe,
  input  logic [CODE_W-1:0] kCode,
  output logic [CNT_W-1:0]  count,
  output logic              atTop,
  output logic              atBottom
);
  localparam int MAX_CODE = MAX_LOG - MIN_LOG;
  localparam int LOG_W    = $clog2(MAX_LOG + 1);

  logic [LOG_W-1:0] kLog;
  logic [CNT_W-1:0] newMask;
  logic [CNT_W-1:0] newHalf;
  logic [CNT_W-1:0] modMax;

  always_comb begin
    if (int'(kCode) > MAX_CODE) kLog = LOG_W'(MAX_LOG);
    else                        kLog = LOG_W'(MIN_LOG) + LOG_W'(kCode);
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign newMask[i] = (LOG_W'(i) < kLog);
  end

  assign newHalf = newMask ^ (newMask >> 1);

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      modMax <= newMask;
      count  <= newHalf;
    end else if (strobe.inc) begin
      count <= strobe.wrapUp ? '0 : count + CNT_W'(1);
    end else if (strobe.dec) begin
      count <= strobe.wrapDn ? modMax : count - CNT_W'(1);
    end
  end

  assign atTop    = (count == modMax);
  assign atBottom = (count == '0);

  assert_count_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    count <= modMax);
  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.inc && !atTop) |=> count == $past(count) + CNT_W'(1));
  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.inc && atTop) |=> count == '0);
  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe.dec && !atBottom) |=> count == $past(count) - CNT_W'(1));
  assert_wrap_down_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.dec && atBottom) |=> count == modMax);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!strobe.inc && !strobe.dec && !strobe.load) |=> $stable(count));
  assert_modulus_kept_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(modMax));
endmodule

// File: rtl/pll_kcounter_ctrl.sv
module pll_kcounter_ctrl
  import pll_kcounter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        up,
  input  logic        atTop,
  input  logic        atBottom,
  output kcntStrobe_t strobe,
  output logic        carry,
  output logic        borrow
);
  always_comb begin
    strobe.load   = rst;
    strobe.inc    = !rst && en && up;
    strobe.dec    = !rst && en && !up;
    strobe.wrapUp = strobe.inc && atTop;
    strobe.wrapDn = strobe.dec && atBottom;
  end

  always_ff @(posedge clk) begin
    carry  <= strobe.wrapUp;
    borrow <= strobe.wrapDn;
  end

  assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(carry && borrow));
  assert_carry_single_R7: assert property (@(posedge clk) disable iff (rst)
    carry |=> !carry);
  assert_borrow_single_R7: assert property (@(posedge clk) disable iff (rst)
    borrow |=> !borrow);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !carry && !borrow);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !carry && !borrow);
  assert_reset_priority_R10: assert property (@(posedge clk)
    (rst && en) |=> !carry && !borrow);
endmodule

// File: rtl/pll_kcounter.sv
module pll_kcounter
  import pll_kcounter_pkg::*;
#(
  parameter int CNT_W   = 17,
  parameter int CODE_W  = 4,
  parameter int MIN_LOG = 3,
  parameter int MAX_LOG = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              up,
  input  logic [CODE_W-1:0] kCode,
  output logic [CNT_W-1:0]  count,
  output logic              carry,
  output logic              borrow
);
  kcntStrobe_t strobe;
  logic        atTop;
  logic        atBottom;

  pll_kcounter_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .up       (up),
    .atTop    (atTop),
    .atBottom (atBottom),
    .strobe   (strobe),
    .carry    (carry),
    .borrow   (borrow)
  );

  pll_kcounter_dp #(
    .CNT_W   (CNT_W),
    .CODE_W  (CODE_W),
    .MIN_LOG (MIN_LOG),
    .MAX_LOG (MAX_LOG)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .kCode    (kCode),
    .count    (count),
    .atTop    (atTop),
    .atBottom (atBottom)
  );
endmodule

// File: tb/tb_pll_kcounter.sv
module tb_pll_kcounter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        up = 1'b0;
  logic [3:0]  kCode = 4'd0;
  logic [16:0] count;
  logic        carry;
  logic        borrow;

  int checks = 0;
  int errors = 0;
  int modelK = 8;
  int modelCnt = 4;
  bit modelCarry = 0;
  bit modelBorrow = 0;
  bit done = 0;

  pll_kcounter dut (
    .clk(clk), .rst(rst), .en(en), .up(up), .kCode(kCode),
    .count(count), .carry(carry), .borrow(borrow)
  );

  always #10 clk = ~clk;

  function automatic int kOf(input int code);
    int c;
    c = (code > 14) ? 14 : code;
    return 1 << (3 + c);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (int'(count) != modelCnt || carry !== modelCarry || borrow !== modelBorrow) begin
      errors++;
      $display("FAIL %s: count=%0d carry=%0b borrow=%0b expected count=%0d carry=%0b borrow=%0b",
               tag, count, carry, borrow, modelCnt, modelCarry, modelBorrow);
    end
  endtask

  task automatic tick(input bit r, input bit e, input bit u, input string tag);
    rst = r; en = e; up = u;
    @(posedge clk);
    if (r) begin
      modelK = kOf(int'(kCode)); modelCnt = modelK / 2;
      modelCarry = 0; modelBorrow = 0;
    end else if (e && u) begin
      modelCarry = (modelCnt == modelK - 1);
      modelCnt = modelCarry ? 0 : modelCnt + 1;
      modelBorrow = 0;
    end else if (e) begin
      modelBorrow = (modelCnt == 0);
      modelCnt = modelBorrow ? modelK - 1 : modelCnt - 1;
      modelCarry = 0;
    end else begin
      modelCarry = 0; modelBorrow = 0;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset value for every small code, sweep both directions (R2..R5)
    for (int code = 0; code <= 4; code++) begin
      kCode = 4'(code);
      tick(1, 0, 0, "R1");
      for (int j = 0; j < kOf(code) + 3; j++) tick(0, 1, 1, "R3");
      for (int j = 0; j < 2 * kOf(code) + 3; j++) tick(0, 1, 0, "R5");
      for (int j = 0; j < 3 * kOf(code); j++) tick(0, (j % 5) != 4, (j % 7) < 4, "R2");
    end
    // R6: hold while disabled
    kCode = 4'd1;
    tick(1, 0, 0, "R1");
    for (int j = 0; j < 10; j++) tick(0, 0, j[0], "R6");
    // R4: plain down steps from mid-range
    for (int j = 0; j < 4; j++) tick(0, 1, 0, "R4");
    // R10: reset with enable high wins
    tick(1, 1, 1, "R10");
    tick(1, 1, 0, "R10");
    // R8: change code after reset; wrap stays at K=16
    kCode = 4'd5;
    for (int j = 0; j < 20; j++) tick(0, 1, 1, "R8");
    for (int j = 0; j < 20; j++) tick(0, 1, 0, "R8");
    // R7: alternate direction straddling the wrap point
    kCode = 4'd0;
    tick(1, 0, 0, "R1");
    for (int j = 0; j < 40; j++) tick(0, 1, (j % 12) < 6, "R7");
    // R1: clamped code and largest K, full climb to the carry (R9 range)
    kCode = 4'd15;
    tick(1, 0, 0, "R1");
    tick(0, 1, 0, "R4");
    kCode = 4'd14;
    tick(1, 0, 0, "R1");
    for (int j = 0; j < 65538; j++) tick(0, 1, 1, "R9");
    tick(0, 1, 0, "R5");
    tick(0, 1, 0, "R5");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule